// File: doc/BRIEF.md
# Half-Precision Round-to-Integral Unit

This block takes one binary16 floating-point operand and rounds it to an integral value, keeping the result in binary16 encoding. The caller selects one of five rounding directions per operation: nearest with ties to even, nearest with ties away from zero, toward zero, toward minus infinity and toward plus infinity. Each operation also reports an inexact flag and an invalid flag. A per-operation flush input treats subnormal operands as signed zeros before any other step.

The rounding works directly on the packed bit pattern. For operands whose magnitude is at least one but which still carry fractional bits, the exponent selects a mask over the fraction. An increment is added to the raw pattern, and the masked bits are then cleared. Any carry moves into the exponent on its own. Operands smaller than one in magnitude take a separate path that returns a fixed constant chosen by the sign and the rounding direction. The result and the flags are registered, and `valid_o` follows `valid_i` by one clock.

Top module: `fp16_round_int`

## Requirements
- R1: An operand with a biased exponent (bits 14:10) of 25 or more that is not a NaN is returned unchanged with both flags clear. This includes infinities.
- R2: A NaN operand (exponent 31, fraction nonzero) returns the same sign and payload with fraction bit 9 forced to 1. The invalid flag is set exactly when bit 9 of the input was 0, which marks a signaling NaN. Inexact stays clear.
- R3: An operand of +0 (0x0000) or -0 (0x8000) is returned unchanged with both flags clear.
- R4: A nonzero operand with a biased exponent of 14 or less sets inexact. Under nearest-even it yields ±1.0 (0x3C00 with the input sign) only when the exponent is 14 and the fraction is nonzero, and signed zero otherwise. Under ties-away it yields ±1.0 whenever the exponent is 14, and signed zero otherwise.
- R5: For such an operand (nonzero, magnitude below one), toward minus infinity yields 0xBC00 if the sign is negative and 0x0000 otherwise. Toward plus infinity yields 0x3C00 if the sign is positive and 0x8000 otherwise. Toward zero yields a zero with the input sign.
- R6: For biased exponents 15 to 24, nearest-even rounds to the closest integer, and an exact half goes to the even integer. A carry out of the fraction raises the exponent, so 1023.5 (0x63FF) becomes 1024.0 (0x6400).
- R7: For biased exponents 15 to 24, ties-away rounds halves away from zero. Toward zero truncates. Toward plus infinity rounds positive operands up in magnitude, and toward minus infinity rounds negative operands up in magnitude.
- R8: For biased exponents 15 to 24, inexact is set exactly when the result differs from the operand. Invalid is clear.
- R9: When `ftz_i` is 1, a subnormal operand (exponent 0, fraction nonzero) is treated as a zero of the same sign. The result is that zero and no flag is raised.
- R10: The `rmode_i` encoding is: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 ties-away. The codes 5, 6 and 7 behave as nearest-even.
- R11: `result_o` and the flags are updated on the clock edge that samples `valid_i` = 1, and `valid_o` is 1 for the following cycle. While `valid_i` is 0 the outputs hold. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand valid |
| operand_i | input | 16 | binary16 operand |
| rmode_i | input | 3 | Rounding direction select |
| ftz_i | input | 1 | Flush subnormal operands to signed zero |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 16 | Rounded binary16 result |
| inexact_o | output | 1 | Result differs from the operand |
| invalid_o | output | 1 | Operand was a signaling NaN |

## Verification
The bench targets exact halves such as 2.5, 3.5 and -2.5. A design that rounds ties upward gives 3.0 instead of 2.0 under nearest-even, and one that ignores the sign in the directed modes moves -2.5 the wrong way. The carry case 1023.5 catches a mask that drops the exponent increment. The value 0.5 separates nearest-even from ties-away in the below-one path, where a wrong comparison turns a zero into 1.0. Signaling and quiet NaNs, signed zeros, flushed subnormals, unused mode codes and held outputs while `valid_i` is low each expose a wrong flag, a lost sign or a spurious update.

// File: rtl/fp16_rti_pkg.sv
package fp16_rti_pkg;
  typedef enum logic [2:0] {
    RM_NE = 3'd0,
    RM_TZ = 3'd1,
    RM_DN = 3'd2,
    RM_UP = 3'd3,
    RM_NA = 3'd4
  } rmode_e;

  function automatic rmode_e decode_mode(logic [2:0] code);
    rmode_e m;
    case (code)
      3'd1:    m = RM_TZ;
      3'd2:    m = RM_DN;
      3'd3:    m = RM_UP;
      3'd4:    m = RM_NA;
      default: m = RM_NE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/fp16_rti_special.sv
module fp16_rti_special #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0] x_i,
  output logic            is_nan_o,
  output logic            is_snan_o,
  output logic [FP_W-1:0] quiet_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;

  assign exp_w     = x_i[FP_W-2 -: EXP_W];
  assign man_w     = x_i[MAN_W-1:0];
  assign is_nan_o  = (exp_w == EXP_MAX) && (man_w != '0);
  assign is_snan_o = is_nan_o && !man_w[MAN_W-1];
  assign quiet_o   = x_i | (FP_W'(1) << (MAN_W - 1));
endmodule

// File: rtl/fp16_rti_small.sv
module fp16_rti_small
  import fp16_rti_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             man_nz_i,
  input  rmode_e           mode_i,
  output logic [FP_W-1:0]  res_o
);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [FP_W-2:0]  MAG_ONE  = {EXP_W'(BIAS), {MAN_W{1'b0}}};

  logic to_one;

  always_comb begin
    case (mode_i)
      RM_NE:   to_one = (exp_i == EXP_HALF) && man_nz_i;
      RM_NA:   to_one = (exp_i == EXP_HALF);
      RM_UP:   to_one = !sign_i;
      RM_DN:   to_one = sign_i;
      default: to_one = 1'b0;
    endcase
    res_o = {sign_i, to_one ? MAG_ONE : '0};
  end
endmodule

// File: rtl/fp16_rti_mask.sv
module fp16_rti_mask
  import fp16_rti_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int INT_EXP = BIAS + MAN_W
) (
  input  logic [FP_W-1:0] x_i,
  input  rmode_e          mode_i,
  output logic [FP_W-1:0] res_o
);
  logic [EXP_W-1:0] sh;
  logic [FP_W-1:0]  last_bit, rmask, z;

  assign sh       = EXP_W'(INT_EXP) - x_i[FP_W-2 -: EXP_W];
  assign last_bit = FP_W'(1) << sh;
  assign rmask    = last_bit - FP_W'(1);

  always_comb begin
    z = x_i;
    case (mode_i)
      RM_NE: begin
        z = x_i + (last_bit >> 1);
        if ((z & rmask) == '0) z = z & ~last_bit;  // exact tie: force even
      end
      RM_NA:   z = x_i + (last_bit >> 1);
      RM_UP:   if (!x_i[FP_W-1]) z = x_i + rmask;
      RM_DN:   if (x_i[FP_W-1])  z = x_i + rmask;
      default: z = x_i;
    endcase
    res_o = z & ~rmask;
  end
endmodule

// File: rtl/fp16_round_int.sv
module fp16_round_int
  import fp16_rti_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int FP_W = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int INT_EXP = BIAS + MAN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [FP_W-1:0] operand_i,
  input  logic [2:0]      rmode_i,
  input  logic            ftz_i,
  output logic            valid_o,
  output logic [FP_W-1:0] result_o,
  output logic            inexact_o,
  output logic            invalid_o
);
  rmode_e           mode;
  logic [FP_W-1:0]  x;
  logic [EXP_W-1:0] exp_w;
  logic             man_nz, is_nan, is_snan;
  logic [FP_W-1:0]  quiet_res, small_res, mask_res;
  logic [FP_W-1:0]  res_d;
  logic             nx_d, nv_d;

  assign mode   = decode_mode(rmode_i);
  assign x      = (ftz_i && operand_i[FP_W-2 -: EXP_W] == '0)
                  ? {operand_i[FP_W-1], {(FP_W-1){1'b0}}} : operand_i;
  assign exp_w  = x[FP_W-2 -: EXP_W];
  assign man_nz = x[MAN_W-1:0] != '0;

  fp16_rti_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_special (
    .x_i(x), .is_nan_o(is_nan), .is_snan_o(is_snan), .quiet_o(quiet_res)
  );

  fp16_rti_small #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_small (
    .sign_i(x[FP_W-1]), .exp_i(exp_w), .man_nz_i(man_nz),
    .mode_i(mode), .res_o(small_res)
  );

  fp16_rti_mask #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mask (
    .x_i(x), .mode_i(mode), .res_o(mask_res)
  );

  always_comb begin
    res_d = x;
    nx_d  = 1'b0;
    nv_d  = 1'b0;
    if (exp_w >= EXP_W'(INT_EXP)) begin
      if (is_nan) begin
        res_d = quiet_res;
        nv_d  = is_snan;
      end
    end else if (exp_w <= EXP_W'(BIAS - 1)) begin
      if (x[FP_W-2:0] != '0) begin
        res_d = small_res;
        nx_d  = 1'b1;
      end
    end else begin
      res_d = mask_res;
      nx_d  = mask_res != x;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        inexact_o <= nx_d;
        invalid_o <= nv_d;
      end
    end
  end

  assert_valid_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(inexact_o) && $stable(invalid_o));
  assert_zero_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && operand_i[FP_W-2:0] == '0 |=>
      result_o == $past(operand_i) && !inexact_o && !invalid_o);
  assert_big_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && operand_i[FP_W-2 -: EXP_W] >= EXP_W'(INT_EXP) && !is_nan |=>
      result_o == $past(operand_i) && !inexact_o && !invalid_o);
  assert_nan_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_nan |=> result_o[FP_W-2 -: EXP_W+1] == '1 && !inexact_o);
  assert_small_inexact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ftz_i && operand_i[FP_W-2:0] != '0 &&
      operand_i[FP_W-2 -: EXP_W] <= EXP_W'(BIAS - 1) |=> inexact_o && !invalid_o);
  assert_invalid_nan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> result_o[FP_W-2 -: EXP_W] == '1);
endmodule

// File: tb/fp16_round_int_tb.sv
`timescale 1ns/1ps
module fp16_round_int_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] operand = '0;
  logic [2:0]  rmode = '0;
  logic        ftz = 1'b0;
  logic        valid_o, inexact_o, invalid_o;
  logic [15:0] result_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [2:0] NE = 3'd0, TZ = 3'd1, DN = 3'd2, UP = 3'd3, NA = 3'd4;

  always #4 clk = ~clk;

  fp16_round_int u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .operand_i(operand),
    .rmode_i(rmode), .ftz_i(ftz), .valid_o(valid_o), .result_o(result_o),
    .inexact_o(inexact_o), .invalid_o(invalid_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual res=%h nx=%b nv=%b valid=%b expected res=%h nx=%b nv=%b valid=%b",
               req, act[15:0], act[16], act[17], act[18],
               exp_v[15:0], exp_v[16], exp_v[17], exp_v[18]);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] op, input logic [2:0] m,
                       input logic f, input logic [15:0] er, input logic enx, input logic env);
    @(negedge clk);
    operand = op; rmode = m; ftz = f; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(req, {valid_o, invalid_o, inexact_o, result_o}, {1'b1, env, enx, er});
  endtask

  task automatic t_reset;
    chk("R11 reset", {valid_o, invalid_o, inexact_o, result_o}, 19'd0);
  endtask

  task automatic t_large;
    apply("R1 inf", 16'h7C00, NE, 1'b0, 16'h7C00, 1'b0, 1'b0);
    apply("R1 -inf", 16'hFC00, UP, 1'b0, 16'hFC00, 1'b0, 1'b0);
    apply("R1 1024", 16'h6400, DN, 1'b0, 16'h6400, 1'b0, 1'b0);
  endtask

  task automatic t_nan;
    apply("R2 qnan", 16'h7E01, NE, 1'b0, 16'h7E01, 1'b0, 1'b0);
    apply("R2 snan", 16'h7C01, TZ, 1'b0, 16'h7E01, 1'b0, 1'b1);
    apply("R2 neg snan", 16'hFD00, UP, 1'b0, 16'hFF00, 1'b0, 1'b1);
  endtask

  task automatic t_zero;
    apply("R3 +0", 16'h0000, UP, 1'b0, 16'h0000, 1'b0, 1'b0);
    apply("R3 -0", 16'h8000, DN, 1'b0, 16'h8000, 1'b0, 1'b0);
  endtask

  task automatic t_small_near;
    apply("R4 0.5 ne", 16'h3800, NE, 1'b0, 16'h0000, 1'b1, 1'b0);
    apply("R4 0.5 na", 16'h3800, NA, 1'b0, 16'h3C00, 1'b1, 1'b0);
    apply("R4 0.75 ne", 16'h3A00, NE, 1'b0, 16'h3C00, 1'b1, 1'b0);
    apply("R4 -0.75 ne", 16'hBA00, NE, 1'b0, 16'hBC00, 1'b1, 1'b0);
    apply("R4 -0.25 na", 16'hB400, NA, 1'b0, 16'h8000, 1'b1, 1'b0);
  endtask

  task automatic t_small_dir;
    apply("R5 -0.75 up", 16'hBA00, UP, 1'b0, 16'h8000, 1'b1, 1'b0);
    apply("R5 -0.75 dn", 16'hBA00, DN, 1'b0, 16'hBC00, 1'b1, 1'b0);
    apply("R5 -0.75 tz", 16'hBA00, TZ, 1'b0, 16'h8000, 1'b1, 1'b0);
    apply("R5 0.5 up", 16'h3800, UP, 1'b0, 16'h3C00, 1'b1, 1'b0);
    apply("R5 0.5 dn", 16'h3800, DN, 1'b0, 16'h0000, 1'b1, 1'b0);
    apply("R5 subn up", 16'h0001, UP, 1'b0, 16'h3C00, 1'b1, 1'b0);
  endtask

  task automatic t_normal_ne;
    apply("R6 2.5", 16'h4100, NE, 1'b0, 16'h4000, 1'b1, 1'b0);
    apply("R6 3.5", 16'h4300, NE, 1'b0, 16'h4400, 1'b1, 1'b0);
    apply("R6 -2.5", 16'hC100, NE, 1'b0, 16'hC000, 1'b1, 1'b0);
    apply("R6 2.25", 16'h4080, NE, 1'b0, 16'h4000, 1'b1, 1'b0);
    apply("R6 1023.5", 16'h63FF, NE, 1'b0, 16'h6400, 1'b1, 1'b0);
  endtask

  task automatic t_normal_dir;
    apply("R7 2.5 na", 16'h4100, NA, 1'b0, 16'h4200, 1'b1, 1'b0);
    apply("R7 2.5 tz", 16'h4100, TZ, 1'b0, 16'h4000, 1'b1, 1'b0);
    apply("R7 2.5 up", 16'h4100, UP, 1'b0, 16'h4200, 1'b1, 1'b0);
    apply("R7 2.25 up", 16'h4080, UP, 1'b0, 16'h4200, 1'b1, 1'b0);
    apply("R7 -2.5 dn", 16'hC100, DN, 1'b0, 16'hC200, 1'b1, 1'b0);
    apply("R7 -2.5 up", 16'hC100, UP, 1'b0, 16'hC000, 1'b1, 1'b0);
    apply("R7 2.5 dn", 16'h4100, DN, 1'b0, 16'h4000, 1'b1, 1'b0);
  endtask

  task automatic t_exact;
    apply("R8 1.0", 16'h3C00, UP, 1'b0, 16'h3C00, 1'b0, 1'b0);
    apply("R8 -3.0", 16'hC200, NA, 1'b0, 16'hC200, 1'b0, 1'b0);
  endtask

  task automatic t_ftz;
    apply("R9 ftz +subn", 16'h0001, UP, 1'b1, 16'h0000, 1'b0, 1'b0);
    apply("R9 ftz -subn", 16'h8005, DN, 1'b1, 16'h8000, 1'b0, 1'b0);
    apply("R9 noftz -subn", 16'h8005, DN, 1'b0, 16'hBC00, 1'b1, 1'b0);
  endtask

  task automatic t_modes;
    apply("R10 code7", 16'h4100, 3'd7, 1'b0, 16'h4000, 1'b1, 1'b0);
    apply("R10 code5", 16'h3800, 3'd5, 1'b0, 16'h0000, 1'b1, 1'b0);
    apply("R10 code6", 16'h4300, 3'd6, 1'b0, 16'h4400, 1'b1, 1'b0);
  endtask

  task automatic t_hold;
    apply("R11 load", 16'h4100, UP, 1'b0, 16'h4200, 1'b1, 1'b0);
    @(negedge clk);
    operand = 16'h7C01; rmode = NE;
    @(negedge clk);
    @(negedge clk);
    chk("R11 hold", {valid_o, invalid_o, inexact_o, result_o}, {1'b0, 1'b0, 1'b1, 16'h4200});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_large();
    t_nan();
    t_zero();
    t_small_near();
    t_small_dir();
    t_normal_ne();
    t_normal_dir();
    t_exact();
    t_ftz();
    t_modes();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule